// File: doc/BRIEF.md
# Translating Lookaside Buffer with Two-Level Table Walker

This block translates 32-bit virtual addresses from a processor into real addresses for a physically addressed cache. A small fully associative buffer holds recent translations. When a lookup hits, the real address comes back on the cycle after the request is accepted. The upper 20 bits are replaced by the stored physical page number, and the 12-bit page offset passes through unchanged.

When a lookup misses, a hardware walker reads a two-level page table in main memory through a single word-read port. It makes one read per level. If both entries are valid, it writes the translation into the buffer and replays the original lookup, which then hits. If either entry is marked invalid, the walker returns a page-fault response and the buffer is left unchanged. Only one processor request is in flight at a time. A flush input drops every cached translation.

Top module: `tlb_walker`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid`, `rsp_fault` and `mem_req_valid` are low, and the buffer holds no translation, so the first access to any page walks the table.
- R2: The virtual address splits into a first-level index in bits 31:22, a second-level index in bits 21:12 and a page offset in bits 11:0. The first walk read goes to `ROOT_BASE + 4*index1`. The second goes to `{base, index2, 2'b00}`, where base is bits 31:12 of the first-level entry.
- R3: A request accepted while its page is cached gets `rsp_valid` high one cycle after acceptance. `rsp_paddr` is `{ppn, offset}` and no memory read is made. Hits can be accepted on consecutive cycles.
- R4: A request that misses makes exactly two memory reads, first level then second level. It then fills the buffer and returns the translated address. A later request to the same page hits.
- R5: In both table levels, bit 0 of an entry is its valid flag and bits 31:12 carry the payload. The payload is the second-level table base at the first level and the physical page number at the second level.
- R6: An invalid first-level entry gives a response with `rsp_fault` high after one read. An invalid second-level entry gives a fault after two reads. Neither fills the buffer, so repeating the request walks again.
- R7: The buffer has `ENTRIES` (8) slots filled in round-robin order. After eight pages are cached, a ninth evicts the oldest one, and the other seven still hit.
- R8: Asserting `flush` for one cycle invalidates every entry, so every later access walks.
- R9: `req_ready` stays low from the acceptance of a missing request until its response. Only one request is outstanding.
- R10: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_rsp_valid` is returned.
- R11: A request accepted in the same cycle as `flush` is treated as a miss, even if its page was cached.
- R12: `rsp_fault` is only ever high together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Processor presents a virtual address |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Translated real address |
| rsp_fault | output | 1 | Response is a page fault |
| mem_req_valid | output | 1 | Page-table read request, held until answered |
| mem_req_addr | output | 32 | Word address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page-table entry word |

## Verification
The bench goes after eviction order. It fills all eight slots, brings in a ninth page, and then checks which old pages still hit. A pointer that restarts or skips a slot would make a still-cached page walk, and the bench would see unexpected reads. Faults at each level are repeated so that a design that wrongly fills the buffer on a fault is caught: its second attempt would make no memory reads. A flush on the same cycle as a request to a cached page must force a walk; a design that gives the stale hit priority returns with zero reads. Every walk address is compared with the index arithmetic, which catches swapped index fields or a word offset that is not scaled by four.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int          ENTRIES   = 8,
  parameter logic [31:0] ROOT_BASE = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        mem_req_valid,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_RETRY} state_t;
  state_t state;

  logic [19:0]      vpn_q [ENTRIES];
  logic [19:0]      ppn_q [ENTRIES];
  logic [ENTRIES-1:0] val_q;
  logic [PTR_W-1:0] rr_q;
  logic [31:0]      va_q;
  logic [19:0]      base_q;

  logic [19:0]        look_vpn;
  logic [ENTRIES-1:0] hit_vec;
  logic [19:0]        hit_ppn;
  logic               hit_any;

  assign look_vpn = (state == S_IDLE) ? req_vaddr[31:12] : va_q[31:12];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = val_q[g] && (vpn_q[g] == look_vpn);
    end
  endgenerate

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
  end

  assign hit_any       = (|hit_vec) && !flush;
  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_L1) || (state == S_L2);
  assign mem_req_addr  = (state == S_L1) ? ROOT_BASE + {20'd0, va_q[31:22], 2'b00}
                                         : {base_q, va_q[21:12], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      val_q     <= '0;
      rr_q      <= '0;
      va_q      <= '0;
      base_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          if (hit_any) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= {hit_ppn, req_vaddr[11:0]};
          end else begin
            state <= S_L1;
          end
        end
        S_L1: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            state     <= S_IDLE;
          end else begin
            base_q <= mem_rsp_data[31:12];
            state  <= S_L2;
          end
        end
        S_L2: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            state     <= S_IDLE;
          end else begin
            vpn_q[rr_q] <= va_q[31:12];
            ppn_q[rr_q] <= mem_rsp_data[31:12];
            val_q[rr_q] <= 1'b1;
            rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
            state       <= S_RETRY;
          end
        end
        S_RETRY: begin
          if (hit_any) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= {hit_ppn, va_q[11:0]};
            state     <= S_IDLE;
          end else begin
            state <= S_L1;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (flush) val_q <= '0;
    end
  end

  // R9: no new request is taken while a table read is pending
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R10: memory request held with a stable address until answered
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2: table reads are word aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R7: at most one slot matches any page
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R3: offset passes through on a good response
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == va_q[11:0]));

  // R12: fault only as part of a response
  a_r12_fault_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid);

  // R6: a fault response leaves the block idle and ready
  a_r6_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> req_ready);
endmodule

// File: tb/tb_tlb_walker.sv
module tb_tlb_walker;
  localparam logic [31:0] ROOT = 32'h0001_0000;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  tlb_walker #(.ENTRIES(8), .ROOT_BASE(ROOT)) dut (.*);

  typedef struct {
    logic [31:0] va;
    int          nrd;
    int          rd0;
    int          t0;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] addr_q[$];
  int checks = 0, errors = 0, reads = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit l1_bad(input logic [31:0] va);
    return va[31:22] == 10'h3F0;
  endfunction
  function automatic bit l2_bad(input logic [31:0] va);
    return va[21:12] == 10'h3FF;
  endfunction
  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    return {va[31:22] ^ 10'h155, va[21:12] ^ 10'h0C3, va[11:0]};
  endfunction

  function automatic logic [31:0] table_word(input logic [31:0] a);
    logic [9:0] i1, i2;
    if (a[31:12] == ROOT[31:12]) begin
      i1 = a[11:2];
      if (i1 == 10'h3F0) return 32'h0;
      return {20'h00100 + {10'd0, i1}, 12'h001};
    end
    i1 = 10'(a[31:12] - 20'h00100);
    i2 = a[11:2];
    if (i2 == 10'h3FF) return 32'h0;
    return {i1 ^ 10'h155, i2 ^ 10'h0C3, 12'h001};
  endfunction

  initial begin : memory_model
    logic [31:0] a;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        a = mem_req_addr;
        reads++;
        if (addr_q.size() == 0) chk(0, "R2 unexpected read", a, 32'h0);
        else begin
          logic [31:0] e;
          e = addr_q.pop_front();
          chk(a == e, "R2 walk address", a, e);
        end
        repeat (LAT) @(negedge clk);
        mem_rsp_data  = table_word(a);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (sb.size() == 0) chk(0, "R9 unexpected response", rsp_paddr, 32'h0);
        else begin
          bit f;
          it = sb.pop_front();
          f  = l1_bad(it.va) || l2_bad(it.va);
          chk(rsp_fault == f, {it.tag, " fault flag"}, 32'(rsp_fault), 32'(f));
          if (!f) chk(rsp_paddr == exp_pa(it.va), {it.tag, " real address"}, rsp_paddr, exp_pa(it.va));
          chk((reads - it.rd0) == it.nrd, {it.tag, " read count"}, reads - it.rd0, it.nrd);
          if (it.nrd == 0) chk(cyc == it.t0 + 1, "R3 hit latency", cyc - it.t0, 1);
        end
      end
    end
  end

  task automatic send(input logic [31:0] va, input int nrd, input bit fl, input string tag);
    item_t it;
    while (!req_ready) @(negedge clk);
    it.va = va; it.nrd = nrd; it.rd0 = reads; it.t0 = cyc; it.tag = tag;
    sb.push_back(it);
    if (nrd >= 1) addr_q.push_back(ROOT + {20'd0, va[31:22], 2'b00});
    if (nrd >= 2) addr_q.push_back({20'h00100 + {10'd0, va[31:22]}, va[21:12], 2'b00});
    req_vaddr = va; req_valid = 1'b1; flush = fl;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    if (nrd > 0) chk(!req_ready, "R9 ready low during walk", 32'(req_ready), 0);
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] pg(input int k, input logic [11:0] off);
    return {10'(k + 3), 10'(k * 7 + 1), off};
  endfunction

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 no read after reset", 32'(mem_req_valid), 0);
    chk(rsp_fault == 1'b0, "R1 no fault after reset", 32'(rsp_fault), 0);

    send(32'h1234_5678, 2, 0, "R1 R4 R5 first miss");
    drain();
    send(32'h1234_5010, 0, 0, "R3 hit other offset");
    send(32'h1234_5FFF, 0, 0, "R3 hit back-to-back");
    send(32'h1234_5000, 0, 0, "R3 hit zero offset");
    drain();

    send({10'h3F0, 10'h011, 12'h044}, 1, 0, "R6 first-level fault");
    drain();
    send({10'h3F0, 10'h011, 12'h044}, 1, 0, "R6 first-level fault repeat");
    drain();
    send({10'h021, 10'h3FF, 12'h800}, 2, 0, "R6 second-level fault");
    drain();
    send({10'h021, 10'h3FF, 12'h800}, 2, 0, "R6 second-level fault repeat");
    drain();

    do_flush();
    send(32'h1234_5678, 2, 0, "R8 walk after flush");
    drain();

    do_flush();
    for (int k = 0; k < 8; k++) begin
      send(pg(k, 12'h0A0), 2, 0, "R7 fill slot");
      drain();
    end
    for (int k = 0; k < 8; k++) send(pg(k, 12'(k)), 0, 0, "R7 all eight hit");
    drain();
    send(pg(8, 12'h111), 2, 0, "R7 ninth page");
    drain();
    send(pg(1, 12'h222), 0, 0, "R7 second oldest kept");
    drain();
    send(pg(0, 12'h333), 2, 0, "R7 oldest evicted");
    drain();
    send(pg(1, 12'h444), 2, 0, "R7 next victim evicted");
    drain();
    send(pg(3, 12'h555), 0, 0, "R7 newer page kept");
    drain();

    send(pg(3, 12'h666), 2, 1, "R11 flush with request");
    drain();
    send(pg(3, 12'h777), 0, 0, "R11 refilled page hits");
    send(pg(4, 12'h010), 2, 0, "R8 other page gone after flush");
    drain();

    finish_run();
  end

  task automatic do_flush;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end
endmodule